// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a small on-chip flash model. Software writes byte-wide commands through a simple write strobe that carries an address and a data byte. The controller decodes single-cycle mode commands and two-cycle program and erase sequences. It launches an external program/erase engine through a start/done handshake. It keeps a status byte with a ready bit, a suspend bit and sticky error flags. It also decides whether a read returns the array data supplied by the storage or that status byte.

An erase in progress can be parked through a suspend request/acknowledge pair and later resumed. While the erase is parked, only a small set of commands is honoured. Error flags build up across several operations and are only cleared by an explicit clear command or by reset. A low-voltage flag is sampled when an operation is confirmed. If it is set, the operation is refused and the failure is recorded.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, reads return array data (`rd_status_o`=0), no start or suspend request is issued, and the status byte reads 8'h80 once status mode is selected.
- R2: Command 8'h70 selects status reads. Command 8'hFF or any unrecognised first-cycle command selects array reads.
- R3: Command 8'h40 followed by any write starts a program. `eng_start_o` pulses for exactly one cycle after the second write, with `eng_erase_o`=0 and the address and data of that second write. Reads switch to status.
- R4: Command 8'h20 followed by 8'hD0 starts an erase. `eng_start_o` pulses with `eng_erase_o`=1 and the confirm write's address, and reads switch to status.
- R5: Command 8'h20 followed by anything other than 8'hD0 starts nothing and sets both bit 4 and bit 5 of the status byte.
- R6: Status bit 7 is 0 from the start pulse until `eng_done_i`, and 1 otherwise. Writes during a busy program, and writes other than 8'hB0 during a busy erase, are ignored.
- R7: `eng_done_i` with `eng_fail_i` sets bit 4 after a program or bit 5 after an erase. Status reads persist after completion.
- R8: Error bits 3..5 are sticky and accumulate until command 8'h50, which clears them when no erase is suspended.
- R9: If `lowv_i` is high on the second write, nothing starts. Bit 3 is set together with bit 4 (program) or bit 5 (erase).
- R10: Command 8'hB0 during an erase raises `eng_susp_req_o`. After `eng_susp_ack_i`, status bits 7 and 6 both read 1.
- R11: If `eng_done_i` arrives while a suspend is pending, the request drops, bit 6 stays 0 and reads return array data.
- R12: While suspended, only 8'hFF (array reads), 8'h70 (status reads) and 8'hD0 (resume) act. Resume drops `eng_susp_req_o`, makes the block busy again and selects status reads. 8'h50 and all other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Command write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data; command in bits 7:0 |
| lowv_i | input | 1 | Programming voltage out of range |
| array_data_i | input | DW | Data read from the array |
| rd_data_o | output | DW | Read data: array data or status byte |
| rd_status_o | output | 1 | 1 when reads return the status byte |
| eng_start_o | output | 1 | One-cycle operation start |
| eng_erase_o | output | 1 | Operation type: 1 erase, 0 program |
| eng_addr_o | output | AW | Operation address |
| eng_data_o | output | DW | Program data |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_fail_i | input | 1 | Failure qualifier for eng_done_i |
| eng_susp_req_o | output | 1 | Erase suspend request (level) |
| eng_susp_ack_i | input | 1 | Engine reports erase parked (pulse) |

## Verification
Several rules are checked on every cycle by assertions:
- a start is a single-cycle pulse, is never issued while the low-voltage flag was high, and always coincides with status reads and a cleared ready bit;
- a suspend request only accompanies an erase;
- error bits never fall except through a clear;
- completion during a pending suspend returns the block to array reads.

Other behaviour depends on the order of commands, so only the bench's scenarios can show it. This covers the two-cycle sequences with their captured address and data, the abort on a bad confirm, accumulation across operations, and the restricted command set while suspended, including the ignored clear.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  localparam int SR_READY = 7;
  localparam int SR_SUSP  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_SET,
    ST_ERASE_SET,
    ST_PROG_BUSY,
    ST_ERASE_BUSY,
    ST_SUSP_PEND,
    ST_SUSPENDED
  } seq_state_e;

  // order matches status bits 5:3
  typedef struct packed {
    logic erase;
    logic prog;
    logic volt;
  } err_flags_t;
endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          lowv_i,
  input  logic          done_i,
  input  logic          fail_i,
  input  logic          susp_ack_i,
  output err_flags_t    err_set_o,
  output logic          clr_o,
  output logic          busy_o,
  output logic          suspended_o,
  output logic          status_mode_o,
  output logic          start_o,
  output logic          op_erase_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          susp_req_o
);
  seq_state_e    state_q, state_d;
  logic          mode_q, mode_d;
  logic          start_q, start_d;
  logic          erase_q, erase_d;
  logic          susp_q, susp_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [7:0]    cmd;

  assign cmd = wr_data_i[7:0];

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    start_d   = 1'b0;
    erase_d   = erase_q;
    susp_d    = susp_q;
    addr_d    = addr_q;
    data_d    = data_q;
    err_set_o = '0;
    clr_o     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_en_i) begin
          case (cmd)
            CMD_PROG_SETUP:  state_d = ST_PROG_SET;
            CMD_ERASE_SETUP: state_d = ST_ERASE_SET;
            CMD_RD_STATUS:   mode_d  = 1'b1;
            CMD_CLR_STATUS:  clr_o   = 1'b1;
            default:         mode_d  = 1'b0;
          endcase
        end
      end
      ST_PROG_SET: begin
        if (wr_en_i) begin
          addr_d  = wr_addr_i;
          data_d  = wr_data_i;
          erase_d = 1'b0;
          mode_d  = 1'b1;
          state_d = ST_IDLE;
          if (lowv_i) begin
            err_set_o.volt = 1'b1;
            err_set_o.prog = 1'b1;
          end else begin
            start_d = 1'b1;
            state_d = ST_PROG_BUSY;
          end
        end
      end
      ST_ERASE_SET: begin
        if (wr_en_i) begin
          mode_d  = 1'b1;
          state_d = ST_IDLE;
          if (cmd == CMD_CONFIRM) begin
            addr_d  = wr_addr_i;
            erase_d = 1'b1;
            if (lowv_i) begin
              err_set_o.volt  = 1'b1;
              err_set_o.erase = 1'b1;
            end else begin
              start_d = 1'b1;
              state_d = ST_ERASE_BUSY;
            end
          end else begin
            err_set_o.prog  = 1'b1;
            err_set_o.erase = 1'b1;
          end
        end
      end
      ST_PROG_BUSY: begin
        if (done_i) begin
          state_d        = ST_IDLE;
          err_set_o.prog = fail_i;
        end
      end
      ST_ERASE_BUSY: begin
        if (done_i) begin
          state_d         = ST_IDLE;
          err_set_o.erase = fail_i;
        end else if (wr_en_i && cmd == CMD_SUSPEND) begin
          susp_d  = 1'b1;
          state_d = ST_SUSP_PEND;
        end
      end
      ST_SUSP_PEND: begin
        if (done_i) begin
          // erase finished before it could park
          state_d         = ST_IDLE;
          susp_d          = 1'b0;
          mode_d          = 1'b0;
          err_set_o.erase = fail_i;
        end else if (susp_ack_i) begin
          state_d = ST_SUSPENDED;
        end
      end
      ST_SUSPENDED: begin
        if (wr_en_i) begin
          case (cmd)
            CMD_RD_ARRAY:  mode_d = 1'b0;
            CMD_RD_STATUS: mode_d = 1'b1;
            CMD_CONFIRM: begin
              susp_d  = 1'b0;
              mode_d  = 1'b1;
              state_d = ST_ERASE_BUSY;
            end
            default: ;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      erase_q <= 1'b0;
      susp_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      erase_q <= erase_d;
      susp_q  <= susp_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign busy_o        = (state_q == ST_PROG_BUSY) || (state_q == ST_ERASE_BUSY) ||
                         (state_q == ST_SUSP_PEND);
  assign suspended_o   = (state_q == ST_SUSPENDED);
  assign status_mode_o = mode_q;
  assign start_o       = start_q;
  assign op_erase_o    = erase_q;
  assign op_addr_o     = addr_q;
  assign op_data_o     = data_q;
  assign susp_req_o    = susp_q;

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> status_mode_o);
  p_lowv_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(lowv_i));
  p_susp_erase_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req_o |-> op_erase_o);
  p_done_in_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP_PEND && done_i) |=> (!susp_req_o && !status_mode_o));
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_flags_t err_set_i,
  input  logic       clr_i,
  input  logic       busy_i,
  input  logic       suspended_i,
  output logic [7:0] sr_o
);
  err_flags_t err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else if (clr_i) err_q <= err_set_i;
    else err_q <= err_q | err_set_i;
  end

  always_comb begin
    sr_o           = '0;
    sr_o[SR_READY] = ~busy_i;
    sr_o[SR_SUSP]  = suspended_i;
    sr_o[5:3]      = err_q;
  end

  for (genvar i = 0; i < 3; i++) begin : g_sticky
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_q[i] && !clr_i) |=> err_q[i]);
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && err_set_i == '0) |=> (sr_o[5:3] == 3'b000));
endmodule

// File: rtl/fcmd_rdmux.sv
module fcmd_rdmux #(
  parameter int DW = 8
) (
  input  logic          sel_status_i,
  input  logic [DW-1:0] array_i,
  input  logic [7:0]    status_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] status_w;

  if (DW > 8) begin : g_pad
    assign status_w = {{(DW-8){1'b0}}, status_i};
  end else begin : g_fit
    assign status_w = status_i;
  end

  assign data_o = sel_status_i ? status_w : array_i;
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          lowv_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_status_o,
  output logic          eng_start_o,
  output logic          eng_erase_o,
  output logic [AW-1:0] eng_addr_o,
  output logic [DW-1:0] eng_data_o,
  input  logic          eng_done_i,
  input  logic          eng_fail_i,
  output logic          eng_susp_req_o,
  input  logic          eng_susp_ack_i
);
  err_flags_t err_set_w;
  logic       clr_w, busy_w, susp_w, mode_w;
  logic [7:0] sr_w;

  fcmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .lowv_i        (lowv_i),
    .done_i        (eng_done_i),
    .fail_i        (eng_fail_i),
    .susp_ack_i    (eng_susp_ack_i),
    .err_set_o     (err_set_w),
    .clr_o         (clr_w),
    .busy_o        (busy_w),
    .suspended_o   (susp_w),
    .status_mode_o (mode_w),
    .start_o       (eng_start_o),
    .op_erase_o    (eng_erase_o),
    .op_addr_o     (eng_addr_o),
    .op_data_o     (eng_data_o),
    .susp_req_o    (eng_susp_req_o)
  );

  fcmd_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_set_i   (err_set_w),
    .clr_i       (clr_w),
    .busy_i      (busy_w),
    .suspended_i (susp_w),
    .sr_o        (sr_w)
  );

  fcmd_rdmux #(.DW(DW)) u_rdmux (
    .sel_status_i (mode_w),
    .array_i      (array_data_i),
    .status_i     (sr_w),
    .data_o       (rd_data_o)
  );

  assign rd_status_o = mode_w;

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> !sr_w[SR_READY]);
endmodule

// File: tb/fcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module fcmd_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        lowv_i = 1'b0;
  logic [7:0]  array_data_i = 8'h5A;
  logic [7:0]  rd_data_o;
  logic        rd_status_o, eng_start_o, eng_erase_o, eng_susp_req_o;
  logic [15:0] eng_addr_o;
  logic [7:0]  eng_data_o;
  logic        eng_done_i = 1'b0, eng_fail_i = 1'b0, eng_susp_ack_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #10 clk_i = ~clk_i;

  fcmd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .lowv_i(lowv_i), .array_data_i(array_data_i),
    .rd_data_o(rd_data_o), .rd_status_o(rd_status_o), .eng_start_o(eng_start_o),
    .eng_erase_o(eng_erase_o), .eng_addr_o(eng_addr_o), .eng_data_o(eng_data_o),
    .eng_done_i(eng_done_i), .eng_fail_i(eng_fail_i),
    .eng_susp_req_o(eng_susp_req_o), .eng_susp_ack_i(eng_susp_ack_i)
  );

  // behavioural reference: phase 0 idle, 1/2 awaiting second write,
  // 3 programming, 4 erasing, 5 suspend asked, 6 parked
  int         m_ph;
  bit         m_stat, m_start, m_erase, m_susp;
  bit [2:0]   m_err;
  bit [15:0]  m_addr;
  bit [7:0]   m_data;

  function automatic bit [7:0] m_sr();
    bit busy = (m_ph == 3) || (m_ph == 4) || (m_ph == 5);
    return {~busy, m_ph == 6, m_err, 3'b000};
  endfunction

  task automatic model_step();
    if (!rst_ni) begin
      m_ph = 0; m_stat = 0; m_start = 0; m_erase = 0; m_susp = 0;
      m_err = 0; m_addr = 0; m_data = 0;
      return;
    end
    m_start = 0;
    case (m_ph)
      0: if (wr_en_i) begin
           if (wr_data_i == 8'h40) m_ph = 1;
           else if (wr_data_i == 8'h20) m_ph = 2;
           else if (wr_data_i == 8'h70) m_stat = 1;
           else if (wr_data_i == 8'h50) m_err = 0;
           else m_stat = 0;
         end
      1: if (wr_en_i) begin
           m_addr = wr_addr_i; m_data = wr_data_i; m_erase = 0; m_stat = 1; m_ph = 0;
           if (lowv_i) m_err = m_err | 3'b011;
           else begin m_start = 1; m_ph = 3; end
         end
      2: if (wr_en_i) begin
           m_stat = 1; m_ph = 0;
           if (wr_data_i == 8'hD0) begin
             m_addr = wr_addr_i; m_erase = 1;
             if (lowv_i) m_err = m_err | 3'b101;
             else begin m_start = 1; m_ph = 4; end
           end else m_err = m_err | 3'b110;
         end
      3: if (eng_done_i) begin
           m_ph = 0;
           if (eng_fail_i) m_err = m_err | 3'b010;
         end
      4: if (eng_done_i) begin
           m_ph = 0;
           if (eng_fail_i) m_err = m_err | 3'b100;
         end else if (wr_en_i && wr_data_i == 8'hB0) begin
           m_susp = 1; m_ph = 5;
         end
      5: if (eng_done_i) begin
           m_ph = 0; m_susp = 0; m_stat = 0;
           if (eng_fail_i) m_err = m_err | 3'b100;
         end else if (eng_susp_ack_i) m_ph = 6;
      6: if (wr_en_i) begin
           if (wr_data_i == 8'hFF) m_stat = 0;
           else if (wr_data_i == 8'h70) m_stat = 1;
           else if (wr_data_i == 8'hD0) begin m_susp = 0; m_stat = 1; m_ph = 4; end
         end
      default: m_ph = 0;
    endcase
  endtask

  initial forever begin
    @(posedge clk_i);
    model_step();
    #5;
    if (cmp_on) begin
      logic [7:0] exp_rd;
      bit ok;
      exp_rd = m_stat ? m_sr() : array_data_i;
      ok = (rd_data_o == exp_rd) && (rd_status_o == m_stat) &&
           (eng_start_o == m_start) && (eng_susp_req_o == m_susp);
      if (m_start)
        ok = ok && (eng_erase_o == m_erase) && (eng_addr_o == m_addr) &&
             (!(m_erase == 0) || eng_data_o == m_data);
      checks++;
      if (!ok) begin
        failures++;
        $display("FAIL R2 model compare t=%0t: rd=%h/%h stat=%b/%b start=%b/%b susp=%b/%b",
                 $time, rd_data_o, exp_rd, rd_status_o, m_stat, eng_start_o, m_start,
                 eng_susp_req_o, m_susp);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [15:0] a = 16'h0, input bit lv = 1'b0);
    wr_en_i = 1'b1; wr_data_i = d; wr_addr_i = a; lowv_i = lv;
    @(negedge clk_i);
    wr_en_i = 1'b0; lowv_i = 1'b0;
  endtask

  task automatic done(input bit f);
    eng_done_i = 1'b1; eng_fail_i = f;
    @(negedge clk_i);
    eng_done_i = 1'b0; eng_fail_i = 1'b0;
  endtask

  task automatic ack();
    eng_susp_ack_i = 1'b1;
    @(negedge clk_i);
    eng_susp_ack_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 status sel", rd_status_o, 0);
    chk("R1 array data", rd_data_o, 8'h5A);
    chk("R1 no start", eng_start_o, 0);
    chk("R1 no susp", eng_susp_req_o, 0);
    wr(8'h70);
    chk("R1 sr after reset", rd_data_o, 8'h80);
    // R2 mode commands
    wr(8'hFF);
    chk("R2 FF array", rd_status_o, 0);
    wr(8'h70);
    wr(8'h33);
    chk("R2 unknown -> array", rd_status_o, 0);
    // R3 program
    wr(8'h40);
    wr(8'hA5, 16'h1234);
    chk("R3 start", eng_start_o, 1);
    chk("R3 op type", eng_erase_o, 0);
    chk("R3 addr", eng_addr_o, 16'h1234);
    chk("R3 data", eng_data_o, 8'hA5);
    chk("R6 busy sr", rd_data_o, 8'h00);
    @(negedge clk_i);
    chk("R3 single pulse", eng_start_o, 0);
    wr(8'hFF);
    chk("R6 write ignored busy", rd_status_o, 1);
    done(1'b0);
    chk("R7 status persists", rd_status_o, 1);
    chk("R6 ready after done", rd_data_o, 8'h80);
    // R7 / R8 failures accumulate
    wr(8'h40); wr(8'h3C, 16'h0010); done(1'b1);
    chk("R7 program fail", rd_data_o, 8'h90);
    wr(8'h20); wr(8'hD0, 16'h0800);
    chk("R4 start", eng_start_o, 1);
    chk("R4 op type", eng_erase_o, 1);
    chk("R4 addr", eng_addr_o, 16'h0800);
    done(1'b1);
    chk("R8 accumulate", rd_data_o, 8'hB0);
    wr(8'h50);
    chk("R8 clear", rd_data_o, 8'h80);
    // R5 bad confirm
    wr(8'h20); wr(8'h40);
    chk("R5 no start", eng_start_o, 0);
    chk("R5 sr", rd_data_o, 8'hB0);
    wr(8'h50);
    // R9 low voltage
    wr(8'h40); wr(8'h77, 16'h0002, 1'b1);
    chk("R9 prog no start", eng_start_o, 0);
    chk("R9 prog sr", rd_data_o, 8'h98);
    wr(8'h50);
    wr(8'h20); wr(8'hD0, 16'h0000, 1'b1);
    chk("R9 erase sr", rd_data_o, 8'hA8);
    wr(8'h50);
    // R10 / R12 suspend
    wr(8'h40); wr(8'h11); done(1'b1);
    wr(8'h20); wr(8'hD0, 16'h0400);
    wr(8'hB0);
    chk("R10 susp req", eng_susp_req_o, 1);
    chk("R10 still busy", rd_data_o, 8'h10);
    ack();
    chk("R10 parked sr", rd_data_o, 8'hD0);
    wr(8'h50);
    chk("R12 clear ignored", rd_data_o, 8'hD0);
    wr(8'hFF);
    chk("R12 array read", rd_data_o, 8'h5A);
    wr(8'h40); wr(8'h55);
    chk("R12 no program", eng_start_o, 0);
    chk("R12 still array", rd_status_o, 0);
    wr(8'h70);
    chk("R12 status read", rd_data_o, 8'hD0);
    wr(8'hD0);
    chk("R12 resume req drop", eng_susp_req_o, 0);
    chk("R12 resume busy", rd_data_o, 8'h10);
    done(1'b0);
    chk("R12 done after resume", rd_data_o, 8'h90);
    // R11 finish while suspend pending
    wr(8'h50);
    wr(8'h20); wr(8'hD0, 16'h0C00); wr(8'hB0);
    done(1'b0);
    chk("R11 req drop", eng_susp_req_o, 0);
    chk("R11 array mode", rd_status_o, 0);
    wr(8'h70);
    chk("R11 sr", rd_data_o, 8'h80);
    // R1 reset clears errors
    wr(8'h40); wr(8'h01); done(1'b1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset array", rd_status_o, 0);
    wr(8'h70);
    chk("R1 reset clears sr", rd_data_o, 8'h80);
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule